// File: doc/BRIEF.md
# Single-Wire Self-Clocked Telemetry Encoder

This block turns one finished measurement into a burst on a single output wire that carries its own timing, so a receiver needs no clock line. A frame source offers a 2-bit channel tag, a 10-bit sample and a 3-bit fault code on a valid/ready input. When the block takes the frame, it sends 18 bits most-significant first. Two timing bits come first: a leading bit of value 0 and a second bit of value 1. Then follow the channel tag, the sample, the fault code, and an even-parity bit over those 15 payload bits.

Every bit is split into two halves of equal length. The first half carries the bit's value and the second half carries its complement, so each bit has an edge in its middle. The half length is a parameter counted in system clock cycles. A receiver times the edges of the two timing bits to learn the rate. The default value gives roughly 15.3 kbit/s from a 50 MHz clock, and a receiver should allow ±20% on that rate. Between frames the wire rests high.

Back-pressure rules: `in_ready` is high exactly while no frame is in flight. A frame moves on a clock edge where `in_valid` and `in_ready` are both high. While a frame is being sent, `in_valid` is ignored. A source may hold `in_valid` high and wait, and its frame is taken on the first edge where `in_ready` is high again. This allows frames to run back to back.

Top module: `swb_tx`

## Requirements
- R1: After reset and at every moment `busy_o` is low, `line_o` is high.
- R2: `in_ready` equals the inverse of `busy_o`. `in_valid` while busy has no effect on the frame in flight or on the wire.
- R3: In the cycle after acceptance, `line_o` is low and `busy_o` is high. The leading bit has value 0, so its first half is low.
- R4: Bits go out in this order, counted from frame bit 17 down to 0: bit 17 = 0, bit 16 = 1, bits 15..14 = channel[1:0], bits 13..4 = sample[9:0], bits 3..1 = fault[2:0], bit 0 = parity.
- R5: Each bit drives its value for `HALF_CLKS` cycles and then its complement for `HALF_CLKS` cycles.
- R6: The parity bit is the XOR of the 15 payload bits, so that the payload plus parity has an even count of ones.
- R7: `busy_o` stays high for exactly 36×`HALF_CLKS` cycles. On the edge it falls, `line_o` returns high. A frame offered in that same cycle is accepted on the next edge, with no idle gap.
- R8: The fields are captured at acceptance. Changing the inputs later does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Block can take a frame |
| in_chan | input | 2 | Channel tag |
| in_sample | input | 10 | Measurement value |
| in_fault | input | 3 | Fault code |
| line_o | output | 1 | Self-clocked serial wire, idles high |
| busy_o | output | 1 | Frame in flight |

## Verification
The bench decodes the wire in every cycle of frames that cover all channel tags and all fault codes, together with several sample patterns including all-zeros and all-ones. A design that swapped field order, dropped the complement half or miscounted the half length would show a wrong level in some cycle. Parity is checked in frames with both odd and even payload weight, which exposes an odd-parity or wrong-span parity bit. The bench holds junk fields with `in_valid` high during a frame, so a design that accepted while busy or did not latch its fields would corrupt the wire. The bench also starts frames back to back in the cycle `busy_o` falls, which catches off-by-one errors at the end of a frame.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int CH_W   = 2;
  localparam int SMP_W  = 10;
  localparam int FLT_W  = 3;
  localparam int PAY_W  = CH_W + SMP_W + FLT_W;
  localparam int FRM_W  = PAY_W + 3;
  localparam logic LEAD_V = 1'b0;
  localparam logic SYNC_V = 1'b1;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [SMP_W-1:0] sample;
    logic [FLT_W-1:0] fault;
  } swb_fields_t;

  typedef logic [FRM_W-1:0] swb_frame_t;
endpackage

// File: rtl/swb_frame_pack.sv
module swb_frame_pack
  import swb_pkg::*;
(
  input  swb_fields_t fields,
  output swb_frame_t  frame
);
  logic par;

  // even parity over the whole payload
  assign par   = ^fields;
  assign frame = {LEAD_V, SYNC_V, fields, par};
endmodule

// File: rtl/swb_half_timer.sv
module swb_half_timer #(
  parameter int HALF_CLKS = 1634
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || tick || !run) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/swb_bit_sequencer.sv
module swb_bit_sequencer
  import swb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  swb_frame_t frame,
  input  logic       tick,
  output logic       busy,
  output logic       line
);
  localparam int IW = $clog2(FRM_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRM_W - 1);

  swb_frame_t    sh;
  logic [IW-1:0] idx;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      idx   <= '0;
      phase <= 1'b0;
      busy  <= 1'b0;
      line  <= 1'b1;
    end else if (load) begin
      sh    <= frame;
      idx   <= '0;
      phase <= 1'b0;
      busy  <= 1'b1;
      line  <= frame[FRM_W-1];
    end else if (busy && tick) begin
      if (!phase) begin
        phase <= 1'b1;
        line  <= ~sh[FRM_W-1];
      end else if (idx == LAST_IDX) begin
        phase <= 1'b0;
        busy  <= 1'b0;
        line  <= 1'b1;
      end else begin
        phase <= 1'b0;
        idx   <= idx + 1'b1;
        sh    <= {sh[FRM_W-2:0], 1'b0};
        line  <= sh[FRM_W-2];
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  // R5
  half_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !phase && !load) |=> (line != $past(line)));

  // R7
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == LAST_IDX && $past(phase)));
endmodule

// File: rtl/swb_tx.sv
module swb_tx
  import swb_pkg::*;
#(
  parameter int HALF_CLKS = 1634
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CH_W-1:0]  in_chan,
  input  logic [SMP_W-1:0] in_sample,
  input  logic [FLT_W-1:0] in_fault,
  output logic             line_o,
  output logic             busy_o
);
  swb_fields_t fields;
  swb_frame_t  frame;
  logic        fire;
  logic        tick;

  assign in_ready = !busy_o;
  assign fire     = in_valid && in_ready;
  assign fields   = '{chan: in_chan, sample: in_sample, fault: in_fault};

  swb_frame_pack u_pack (
    .fields (fields),
    .frame  (frame)
  );

  swb_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fire),
    .run   (busy_o),
    .tick  (tick)
  );

  swb_bit_sequencer u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .frame (frame),
    .tick  (tick),
    .busy  (busy_o),
    .line  (line_o)
  );

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy_o && !line_o));

  // R2
  accept_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(in_valid));
endmodule

// File: tb/swb_tx_bench.sv
module swb_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int FRAME_CYC = 36 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_chan = '0;
  logic [9:0] in_sample = '0;
  logic [2:0] in_fault = '0;
  logic       line_o;
  logic       busy_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swb_tx #(.HALF_CLKS(HALF)) u_swb_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_sample(in_sample), .in_fault(in_fault),
    .line_o(line_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Caller is just after a negedge. Leaves just after a negedge with the frame done.
  task automatic send(input logic [1:0] ch, input logic [9:0] d, input logic [2:0] f,
                      input bit junk);
    logic [17:0] bits;
    int mism;
    int first_k;
    logic first_a;
    logic first_e;
    bits = {1'b0, 1'b1, ch, d, f, ^{ch, d, f}};
    in_valid  = 1'b1;
    in_chan   = ch;
    in_sample = d;
    in_fault  = f;
    check("R2 ready before accept", in_ready, 1'b1);
    @(negedge clk);
    // R3: first sample after acceptance
    check("R3 line low after accept", line_o, 1'b0);
    check("R3 busy after accept", busy_o, 1'b1);
    if (junk) begin
      in_chan   = ~ch;
      in_sample = ~d;
      in_fault  = ~f;
    end else begin
      in_valid = 1'b0;
    end
    mism = 0;
    first_k = 0;
    first_a = 1'b0;
    first_e = 1'b0;
    for (int k = 0; k < FRAME_CYC; k++) begin
      logic e;
      e = bits[17 - k/(2*HALF)] ^ logic'((k/HALF) % 2);
      if (line_o !== e || busy_o !== 1'b1 || in_ready !== 1'b0) begin
        if (mism == 0) begin
          first_k = k;
          first_a = line_o;
          first_e = e;
        end
        mism++;
      end
      if (k == FRAME_CYC - 1) in_valid = 1'b0;
      @(negedge clk);
    end
    // R4 R5 R6 R8: whole waveform per frame
    total++;
    if (mism != 0) begin
      bad++;
      $display("FAIL R4/R5/R6/R8 frame ch=%0d d=%h f=%0d cycle %0d actual=%b expected=%b",
               ch, d, f, first_k, first_a, first_e);
    end
    // R7: idle exactly FRAME_CYC cycles after accept
    check("R7 busy falls", busy_o, 1'b0);
    check("R7 line high at end", line_o, 1'b1);
    check("R7 ready at end", in_ready, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] pats[4];
    pats[0] = 10'h000;
    pats[1] = 10'h3FF;
    pats[2] = 10'h155;
    pats[3] = 10'h2C7;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 line high in reset", line_o, 1'b1);
    check("R2 ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy low after reset", busy_o, 1'b0);
    for (int ch = 0; ch < 4; ch++) begin
      for (int f = 0; f < 8; f++) begin
        for (int p = 0; p < 4; p++) begin
          send(2'(ch), pats[p] ^ 10'(f * 37), 3'(f), ((ch + f + p) % 3) == 0);
          if (((ch + p) % 2) == 0) begin
            // R1: idle gap stays high and ignores nothing offered
            for (int g = 0; g < 5; g++) begin
              @(negedge clk);
              check("R1 idle high between frames", line_o, 1'b1);
            end
          end
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule